// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock for one byte transfer of an I2C master. A reloadable down counter runs on the system clock, which here stands for two evenly spaced phase ticks per instruction cycle. Each time the counter reaches zero it rolls over and reloads itself from a captured 7-bit reload value. Every rollover toggles the SCL drive level. The low half and the high half of a clock period therefore each take one rollover.

A write strobe for the transmit buffer starts the transfer on its own; there is no separate enable. The block then produces nine SCL clocks, eight data bits plus the acknowledge clock. After the ninth clock it freezes with SCL driven low, which is the level it reached last, and it pulses a done flag. The block reads SCL back from the bus. The high half only begins to count once the bus actually reads high, so a slave that stretches the clock, or a slow rising edge, makes the period longer instead of shortening the high half. A sample strobe marks the middle of each high half, for the shift logic that sits beside this block.

Top module: `i2c_scl_rategen`

## Requirements
- R1: While reset is held, and after it is released, SCL drive is high (released), the done flag is low and the sample strobe is low.
- R2: A buffer write while idle starts a transfer. SCL drive is low in the clock cycle that follows the write.
- R3: With R the reload value captured at the write, each low half lasts R+1 clock cycles. Each high half also lasts R+1 clock cycles when SCL reads high throughout. A transfer with no stretching runs 18*(R+1) cycles from the write to the done flag.
- R4: A reload value of 0 is legal and gives halves one clock cycle long. This is the fastest rate.
- R5: During a high half, every cycle in which the sampled SCL input reads low reloads the counter. With S such cycles directly after SCL is released, the high half lasts S+R+1 cycles.
- R6: Each transfer produces exactly nine SCL high pulses. After the last one, SCL drive stays low and the counter stays frozen until the next buffer write.
- R7: The done flag is high for exactly one cycle per transfer, in the same cycle in which SCL drive falls for the last time.
- R8: The sample strobe is high for exactly one cycle in each high half. That cycle is the one with index ceil(R/2), counting from 0 at the first cycle in which SCL drive and the SCL input both read high and no stretch cycle follows. This gives nine strobes per transfer.
- R9: A buffer write while a transfer is active has no effect on the SCL timing. This also holds for a write in the cycle of the final falling edge.
- R10: A change of the reload input during a transfer has no effect until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_val | input | 7 | Half-period reload value R |
| buf_wr | input | 1 | Transmit buffer write strobe, starts a transfer |
| scl_in | input | 1 | SCL level sampled from the bus |
| scl_drive | output | 1 | SCL drive level, 1 = released, 0 = pulled low |
| bit_sample | output | 1 | Mid-high-phase sample strobe |
| xfer_done | output | 1 | One-cycle pulse when the transfer halts |

## Verification
The final rollover of the acknowledge clock and a new buffer write can fall in the same cycle. In that cycle the block halts and pulses done, and it must not take the write as a new start. The bench uses its reference model to spot the cycle in which the last high half is about to roll over, and it raises the write strobe exactly then. It then expects the done pulse, followed by SCL held low and no further clocks. Clock stretching that ends right at the sample point is covered as well: the model compares the strobe and the SCL drive on every cycle.

// File: rtl/i2c_rg_pkg.sv
package i2c_rg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Counter value at which the middle of a high half is reached.
  function automatic int mid_count(input int reload);
    return reload / 2;
  endfunction

endpackage

// File: rtl/brg_down_counter.sv
module brg_down_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         at_zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && !at_zero)   cnt <= cnt - 1'b1;
  end

  assign at_zero = (cnt == '0);

  // Zero is sticky until a reload.
  p_zero_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !load) |=> at_zero);

  // Without a load the count never rises.
  p_no_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import i2c_rg_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       roll,
  output scl_phase_e phase,
  output logic       scl_drive,
  output logic       done
);

  localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PULSES - 1);

  logic [PW-1:0] pulses_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      scl_drive <= 1'b1;
      done      <= 1'b0;
      pulses_q  <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_LOW;
          scl_drive <= 1'b0;
          pulses_q  <= '0;
        end
        PH_LOW: if (roll) begin
          phase     <= PH_HIGH;
          scl_drive <= 1'b1;
        end
        PH_HIGH: if (roll) begin
          scl_drive <= 1'b0;
          if (pulses_q == LAST) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            pulses_q <= pulses_q + 1'b1;
            phase    <= PH_LOW;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // SCL only moves on a rollover or on a start.
  p_scl_moves_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_drive) |-> $past(roll || start));

  p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_drive && phase == PH_IDLE));

  p_idle_holds_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start) |=> $stable(scl_drive));

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= LAST);

endmodule

// File: rtl/i2c_scl_rategen.sv
module i2c_scl_rategen
  import i2c_rg_pkg::*;
#(
  parameter int RLD_W  = 7,
  parameter int PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RLD_W-1:0] reload_val,
  input  logic             buf_wr,
  input  logic             scl_in,
  output logic             scl_drive,
  output logic             bit_sample,
  output logic             xfer_done
);

  scl_phase_e       phase;
  logic [RLD_W-1:0] rl_q;
  logic [RLD_W-1:0] cnt;
  logic [RLD_W-1:0] load_val_w;
  logic [RLD_W-1:0] mid_w;
  logic             at_zero;
  logic             accept_w;
  logic             hi_wait_w;
  logic             run_w;
  logic             roll_w;
  logic             load_w;

  // Named internal events.
  assign accept_w   = buf_wr && (phase == PH_IDLE);
  assign hi_wait_w  = (phase == PH_HIGH) && !scl_in;
  assign run_w      = (phase != PH_IDLE) && !hi_wait_w;
  assign roll_w     = run_w && at_zero;
  assign load_w     = accept_w || roll_w || hi_wait_w;
  assign load_val_w = accept_w ? reload_val : rl_q;
  assign mid_w      = RLD_W'(mid_count(int'(rl_q)));

  always_ff @(posedge clk) begin
    if (!rst_n)        rl_q <= '0;
    else if (accept_w) rl_q <= reload_val;
  end

  brg_down_counter #(.W(RLD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .load_val (load_val_w),
    .run      (run_w),
    .cnt      (cnt),
    .at_zero  (at_zero)
  );

  scl_phase_seq #(.PULSES(PULSES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept_w),
    .roll      (roll_w),
    .phase     (phase),
    .scl_drive (scl_drive),
    .done      (xfer_done)
  );

  assign bit_sample = (phase == PH_HIGH) && scl_in && (cnt == mid_w);

  p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(rl_q));

  p_sample_when_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_sample |-> (scl_drive && scl_in));

  p_stretch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wait_w |=> (cnt == rl_q && phase == PH_HIGH));

  p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (cnt <= rl_q));

endmodule

// File: tb/tb_i2c_scl_rategen.sv
module tb_i2c_scl_rategen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] reload_val = '0;
  logic       buf_wr = 1'b0;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       scl_drive, bit_sample, xfer_done;

  always #2 clk = ~clk;   // 250 MHz

  assign scl_in = scl_drive & ~stretch;

  i2c_scl_rategen dut (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .buf_wr(buf_wr),
    .scl_in(scl_in), .scl_drive(scl_drive), .bit_sample(bit_sample),
    .xfer_done(xfer_done)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: busy flag, half type, ticks elapsed in half.
  bit m_busy = 0, m_high = 0, m_scl = 1, m_done = 0;
  int m_el = 0, m_r = 0, m_pulses = 0;

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_high = 0; m_scl = 1; m_el = 0; m_pulses = 0;
    end else if (!m_busy) begin
      if (buf_wr) begin
        m_busy = 1; m_high = 0; m_el = 0; m_r = int'(reload_val);
        m_pulses = 0; m_scl = 0;
      end
    end else if (!m_high) begin
      if (m_el == m_r) begin m_high = 1; m_el = 0; m_scl = 1; end
      else m_el++;
    end else begin
      if (!scl_in) m_el = 0;
      else if (m_el == m_r) begin
        m_scl = 0; m_pulses++;
        if (m_pulses == 9) begin m_busy = 0; m_done = 1; end
        else begin m_high = 0; m_el = 0; end
      end else m_el++;
    end
  end

  // Per-cycle comparison, plus edge and strobe counters.
  int rises = 0, strobes = 0;
  bit prev_scl = 1;
  bit exp_smp;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_smp = m_busy && m_high && scl_in && (m_el == (m_r + 1) / 2);
      chk(scl_drive == m_scl, "R3 scl_drive vs model", scl_drive, m_scl);
      chk(xfer_done == m_done, "R7 done vs model", xfer_done, m_done);
      chk(bit_sample == exp_smp, "R8 sample vs model", bit_sample, exp_smp);
      if (scl_drive && !prev_scl) rises++;
      if (bit_sample) strobes++;
    end
    prev_scl = scl_drive;
  end

  task automatic write_buf(input logic [6:0] r);
    @(negedge clk); #1;
    reload_val = r; buf_wr = 1'b1;
    @(negedge clk);
    chk(scl_drive == 1'b0, "R2 low after write", scl_drive, 0);
    #1 buf_wr = 1'b0;
  endtask

  // Returns negedges from the one after the write through the done one.
  task automatic wait_done(output int n);
    n = 1;
    while (!xfer_done) begin @(negedge clk); n++; end
  endtask

  task automatic idle_check(input string tag);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(scl_drive == 1'b0 && !xfer_done, tag, scl_drive, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R6 watchdog, transfer never halted", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, lo, hi;
    repeat (3) @(negedge clk);
    chk(scl_drive && !xfer_done && !bit_sample, "R1 in reset", scl_drive, 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(scl_drive && !xfer_done && !bit_sample, "R1 after reset", scl_drive, 1);

    // Basic transfer, R=3
    rises = 0; strobes = 0;
    write_buf(7'd3);
    wait_done(n);
    chk(n == 18 * 4 + 1, "R3 transfer length R=3", n, 18 * 4 + 1);
    chk(rises == 9, "R6 nine pulses", rises, 9);
    chk(strobes == 9, "R8 nine strobes", strobes, 9);
    chk(scl_drive == 1'b0, "R7 done with scl low", scl_drive, 0);
    idle_check("R6 frozen low after halt");

    // Fastest rate, R=0
    rises = 0;
    @(negedge clk); #1; reload_val = 7'd0; buf_wr = 1'b1;
    @(negedge clk); #1 buf_wr = 1'b0;
    lo = 1;
    @(negedge clk);
    while (!scl_drive) begin lo++; @(negedge clk); end
    chk(lo == 1, "R4 low half of one cycle", lo, 1);
    n = 0;
    while (!xfer_done) begin @(negedge clk); n++; end
    chk(rises == 9, "R4 nine pulses at R=0", rises, 9);

    // Clock stretching, R=5, S=7
    write_buf(7'd5);
    @(negedge clk);
    while (!scl_drive) @(negedge clk);
    #1 stretch = 1'b1;
    repeat (7) @(negedge clk);
    #1 stretch = 1'b0;
    hi = 8;
    @(negedge clk);
    while (scl_drive) begin hi++; @(negedge clk); end
    chk(hi == 7 + 5 + 1, "R5 stretched high half", hi, 13);
    wait_done(n);

    // Mid-transfer writes and reload change, R=2
    rises = 0;
    write_buf(7'd2);
    repeat (10) @(negedge clk);
    #1 reload_val = 7'd40; buf_wr = 1'b1;
    @(negedge clk); #1 buf_wr = 1'b0;
    n = 12;
    while (!xfer_done) begin @(negedge clk); n++; end
    chk(n == 18 * 3 + 1, "R10 captured reload kept", n, 55);
    chk(rises == 9, "R9 pulses unchanged by busy write", rises, 9);

    // Write in the cycle of the final falling edge, R=4
    rises = 0;
    write_buf(7'd4);
    @(negedge clk);
    while (!(m_busy && m_high && m_pulses == 8 && m_el == m_r)) @(negedge clk);
    #1 reload_val = 7'd1; buf_wr = 1'b1;
    @(negedge clk);
    chk(xfer_done == 1'b1, "R9 halt on colliding write", xfer_done, 1);
    #1 buf_wr = 1'b0;
    idle_check("R9 colliding write ignored");
    chk(rises == 9, "R6 pulses with colliding write", rises, 9);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule